// File: doc/BRIEF.md
# Two-Port SATA Host Register File

This block is the software-visible register file of a two-port SATA host controller. A processor reaches it over a plain 32-bit bus with a 12-bit byte address, a write strobe and a read-data output that follows the address combinationally. The register file holds a small global window and one register set per port. The global window has capability, control, interrupt summary, implemented-port map and version words. Each port set has command-list and receive-area base addresses, interrupt status and enable, a command word, task-file and signature words, the four link registers and a command-issue word.

The surrounding command engine uses three groups of signals:

- It raises per-port interrupt events through `evt_set`.
- It retires command slots through `slot_done`.
- It receives a one-cycle `kick` pulse whenever software hands work to a port.

The per-port interrupt causes that are enabled are folded into a sticky summary word. The summary drives a single level interrupt line.

Top module: `sata_hba_regs`

## Requirements
- R1: After reset, the capability word reads 0x00001F02, the control word reads 0x80000000, the implemented-port map reads 0x00000001 and the version reads 0x00010100. Every port register reads 0 and `irq` is low.
- R2: Only `bus_addr[11:0]` is decoded.
  - Byte offsets 0x00–0x1F select the global window: capability at 0x00, control at 0x04, interrupt summary at 0x08, port map at 0x0C and version at 0x10. Offsets 0x14–0x1C read 0.
  - Offsets 0x100–0x1FF select a port. The port number is (addr−0x100)>>7 and the register offset is addr&0x7F.
  - Within a port: list base low/high at 0x00/0x04, receive base low/high at 0x08/0x0C, interrupt status 0x10, interrupt enable 0x14, command 0x18, task file 0x20, signature 0x24, link status 0x28, link control 0x2C, link error 0x30, link active 0x34, command issue 0x38. Offsets 0x1C and 0x3C–0x7F read 0.
  - Any address outside both windows reads 0.
- R3: Writes to the capability, control, port-map and version words have no effect.
- R4: A write to a port's command word keeps only the bits selected by 0x0100C01F (bits 24, 15, 14, 4, 3, 2, 1, 0). All other bits read back as 0.
- R5: A port's interrupt status is write-1-to-clear. A bit set through `evt_set` in the same cycle as its clear stays set.
- R6: Summary bit i is set on the clock edge after port i's (status & enable) becomes nonzero. The bit holds until it is cleared by writing 1 to it at 0x08, and a pending port re-sets it in that same cycle. `irq` is high exactly while the summary is nonzero.
- R7: The link status register (offset 0x28) reads 3 for port 0 when `dev_present` is high, and reads 0 otherwise. Writes to it have no effect.
- R8: A write whose `bus_addr[1:0]` is nonzero changes no register and produces no kick.
- R9: `kick[i]` is high for exactly the one cycle after the clock edge that accepts either of these writes to port i: any write to command issue, or a command-word write with bit 0 set.
- R10: A write to command issue replaces its value. Otherwise, each set bit of the port's `slot_done` field clears the matching issue bit. A write wins over a simultaneous `slot_done`.
- R11: List/receive bases, interrupt enable, task file, signature, and the link control, error and active words store and return all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| dev_present | input | 1 | Device attached to port 0 |
| evt_set | input | NPORT*32 | Per-port interrupt status set bits, port i in bits [32i+31:32i] |
| slot_done | input | NPORT*32 | Per-port command-issue clear bits, same packing |
| kick | output | NPORT | Per-port one-cycle work pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the interplay of the sticky summary and the write-1-to-clear port status:

- **Clear while a cause is pending.** The summary is cleared while a port cause is still enabled. A design that clears unconditionally would drop `irq` for a cycle.
- **Set and clear in the same cycle.** A port status bit is cleared in the same cycle it is set. A design with clear priority would lose the event.
- **Misaligned writes.** These are aimed at the command and base words. A decoder that drops the low address bits would corrupt a register or fire `kick`.
- **Command-issue collisions.** A software write and a `slot_done` land on command issue together.
- **Command-word masking.** Random traffic checks the whitelist on the command word against a bench model.

// File: rtl/sata_hba_pkg.sv
package sata_hba_pkg;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;

  localparam logic [DW-1:0] CAP_RST  = 32'h0000_1F02;
  localparam logic [DW-1:0] CTL_RST  = 32'h8000_0000;
  localparam logic [DW-1:0] IMPL_RST = 32'h0000_0001;
  localparam logic [DW-1:0] VER_RST  = 32'h0001_0100;
  localparam logic [DW-1:0] CMD_KEEP = 32'h0100_C01F;
  localparam logic [DW-1:0] LINK_UP  = 32'h0000_0003;

  typedef enum logic [1:0] {WIN_NONE, WIN_GLOBAL, WIN_PORT} win_e;

  typedef enum logic [3:0] {
    PR_LIST_LO, PR_LIST_HI, PR_RX_LO, PR_RX_HI,
    PR_ISTAT, PR_IEN, PR_CMD, PR_TASK, PR_SIGN,
    PR_LSTAT, PR_LCTL, PR_LERR, PR_LACT, PR_ISSUE, PR_HOLE
  } preg_e;

  function automatic win_e win_of(input logic [AW-1:0] a);
    if (a < 12'h020)                        return WIN_GLOBAL;
    else if (a >= 12'h100 && a < 12'h200)   return WIN_PORT;
    else                                    return WIN_NONE;
  endfunction

  function automatic int port_of(input logic [AW-1:0] a);
    return (int'(a) - 256) >>> 7;
  endfunction

  function automatic preg_e preg_of(input logic [AW-1:0] a);
    case (a[6:2])
      5'd0:  return PR_LIST_LO;
      5'd1:  return PR_LIST_HI;
      5'd2:  return PR_RX_LO;
      5'd3:  return PR_RX_HI;
      5'd4:  return PR_ISTAT;
      5'd5:  return PR_IEN;
      5'd6:  return PR_CMD;
      5'd8:  return PR_TASK;
      5'd9:  return PR_SIGN;
      5'd10: return PR_LSTAT;
      5'd11: return PR_LCTL;
      5'd12: return PR_LERR;
      5'd13: return PR_LACT;
      5'd14: return PR_ISSUE;
      default: return PR_HOLE;
    endcase
  endfunction

  function automatic logic [DW-1:0] keep_cmd(input logic [DW-1:0] v);
    return v & CMD_KEEP;
  endfunction

  // set bits win over bits cleared by a write of ones
  function automatic logic [DW-1:0] clr_then_set(input logic [DW-1:0] old,
                                                 input logic [DW-1:0] clr,
                                                 input logic [DW-1:0] set);
    return (old & ~clr) | set;
  endfunction

endpackage

// File: rtl/hba_port_bank.sv
module hba_port_bank
  import sata_hba_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  preg_e         sel,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt_set,
  input  logic [DW-1:0] slot_done,
  input  logic [DW-1:0] lstat_val,
  output logic [DW-1:0] rdata,
  output logic          pend,
  output logic          kick,
  output logic [DW-1:0] istat_o,
  output logic [DW-1:0] ien_o
);

  logic [DW-1:0] list_lo, list_hi, rx_lo, rx_hi;
  logic [DW-1:0] istat, ien, cmd, task_w, sign;
  logic [DW-1:0] lctl, lerr, lact, issue;
  logic          kick_q;

  wire wr_istat = wr_en && (sel == PR_ISTAT);
  wire wr_issue = wr_en && (sel == PR_ISSUE);
  wire wr_cmd   = wr_en && (sel == PR_CMD);
  wire kick_ev  = wr_issue || (wr_cmd && wdata[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      list_lo <= '0; list_hi <= '0; rx_lo <= '0; rx_hi <= '0;
      ien <= '0; cmd <= '0; task_w <= '0; sign <= '0;
      lctl <= '0; lerr <= '0; lact <= '0;
    end else if (wr_en) begin
      case (sel)
        PR_LIST_LO: list_lo <= wdata;
        PR_LIST_HI: list_hi <= wdata;
        PR_RX_LO:   rx_lo   <= wdata;
        PR_RX_HI:   rx_hi   <= wdata;
        PR_IEN:     ien     <= wdata;
        PR_CMD:     cmd     <= keep_cmd(wdata);
        PR_TASK:    task_w  <= wdata;
        PR_SIGN:    sign    <= wdata;
        PR_LCTL:    lctl    <= wdata;
        PR_LERR:    lerr    <= wdata;
        PR_LACT:    lact    <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) istat <= '0;
    else        istat <= clr_then_set(istat, wr_istat ? wdata : '0, evt_set);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        issue <= '0;
    else if (wr_issue) issue <= wdata;
    else               issue <= issue & ~slot_done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) kick_q <= 1'b0;
    else        kick_q <= kick_ev;
  end

  always_comb begin
    case (sel)
      PR_LIST_LO: rdata = list_lo;
      PR_LIST_HI: rdata = list_hi;
      PR_RX_LO:   rdata = rx_lo;
      PR_RX_HI:   rdata = rx_hi;
      PR_ISTAT:   rdata = istat;
      PR_IEN:     rdata = ien;
      PR_CMD:     rdata = cmd;
      PR_TASK:    rdata = task_w;
      PR_SIGN:    rdata = sign;
      PR_LSTAT:   rdata = lstat_val;
      PR_LCTL:    rdata = lctl;
      PR_LERR:    rdata = lerr;
      PR_LACT:    rdata = lact;
      PR_ISSUE:   rdata = issue;
      default:    rdata = '0;
    endcase
  end

  assign pend    = |(istat & ien);
  assign kick    = kick_q;
  assign istat_o = istat;
  assign ien_o   = ien;

endmodule

// File: rtl/hba_global_bank.sv
module hba_global_bank
  import sata_hba_pkg::*;
#(
  parameter int unsigned NPORT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       word,
  input  logic [DW-1:0]    wdata,
  input  logic [NPORT-1:0] pend,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    gstat_o
);

  logic [DW-1:0] gstat;
  logic [DW-1:0] pend_w;
  wire           wr_gstat = wr_en && (word == 3'd2);

  always_comb begin
    pend_w = '0;
    pend_w[NPORT-1:0] = pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gstat <= '0;
    else        gstat <= clr_then_set(gstat, wr_gstat ? wdata : '0, pend_w);
  end

  always_comb begin
    case (word)
      3'd0:    rdata = CAP_RST;
      3'd1:    rdata = CTL_RST;
      3'd2:    rdata = gstat;
      3'd3:    rdata = IMPL_RST;
      3'd4:    rdata = VER_RST;
      default: rdata = '0;
    endcase
  end

  assign gstat_o = gstat;

endmodule

// File: rtl/sata_hba_regs.sv
module sata_hba_regs
  import sata_hba_pkg::*;
#(
  parameter int unsigned NPORT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               dev_present,
  input  logic [NPORT*32-1:0] evt_set,
  input  logic [NPORT*32-1:0] slot_done,
  output logic [NPORT-1:0]   kick,
  output logic               irq
);

  // decode
  win_e  win;
  preg_e psel;
  int    pidx;
  logic  aligned;

  assign win     = win_of(bus_addr);
  assign psel    = preg_of(bus_addr);
  assign pidx    = port_of(bus_addr);
  assign aligned = (bus_addr[1:0] == 2'b00);

  wire g_wr = bus_wr && aligned && (win == WIN_GLOBAL);

  // per-port instances
  logic [DW-1:0]    port_rdata [NPORT];
  logic [NPORT-1:0] pend;
  logic [DW-1:0]    istat_w    [NPORT];
  logic [DW-1:0]    ien_w      [NPORT];

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    wire           hit  = (win == WIN_PORT) && (pidx == i);
    wire [DW-1:0]  lsv  = (i == 0 && dev_present) ? LINK_UP : '0;

    hba_port_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr && aligned && hit),
      .sel       (psel),
      .wdata     (bus_wdata),
      .evt_set   (evt_set[i*32 +: 32]),
      .slot_done (slot_done[i*32 +: 32]),
      .lstat_val (lsv),
      .rdata     (port_rdata[i]),
      .pend      (pend[i]),
      .kick      (kick[i]),
      .istat_o   (istat_w[i]),
      .ien_o     (ien_w[i])
    );
  end

  // global window
  logic [DW-1:0] g_rdata;
  logic [DW-1:0] gstat;

  hba_global_bank #(.NPORT(NPORT)) u_glob (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (g_wr),
    .word    (bus_addr[4:2]),
    .wdata   (bus_wdata),
    .pend    (pend),
    .rdata   (g_rdata),
    .gstat_o (gstat)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (win == WIN_GLOBAL) begin
      bus_rdata = g_rdata;
    end else if (win == WIN_PORT) begin
      for (int i = 0; i < NPORT; i++)
        if (pidx == i) bus_rdata = port_rdata[i];
    end
  end

  assign irq = |gstat;

  // named internal events for the checker
  wire [DW-1:0] chk_istat0 = istat_w[0];
  wire [DW-1:0] chk_ien0   = ien_w[0];

endmodule

// File: rtl/sata_hba_regs_chk.sv
module sata_hba_regs_chk
  import sata_hba_pkg::*;
#(
  parameter int unsigned NPORT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [11:0]        bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               dev_present,
  input logic [NPORT*32-1:0] evt_set,
  input logic [NPORT-1:0]   kick,
  input logic               irq,
  input logic [NPORT-1:0]   pend,
  input logic [31:0]        gstat,
  input logic [31:0]        istat0,
  input logic [31:0]        ien0
);

  p_cap_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 12'h000) |-> (bus_rdata == CAP_RST));

  p_cmd_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 12'h118) |-> ((bus_rdata & ~CMD_KEEP) == 32'h0));

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h110 && evt_set[31:0] == 32'h0)
      |=> ((istat0 & $past(bus_wdata)) == 32'h0));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] |=> gstat[0]);

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|pend));

  p_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 12'h128 && !dev_present) |-> (bus_rdata == 32'h0));

  p_misalign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[1:0] != 2'b00 && evt_set[31:0] == 32'h0)
      |=> ($stable(istat0) && $stable(ien0) && kick == '0));

  p_kick_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kick != '0) |-> $past(bus_wr));

endmodule

bind sata_hba_regs sata_hba_regs_chk #(.NPORT(NPORT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .dev_present (dev_present),
  .evt_set     (evt_set),
  .kick        (kick),
  .irq         (irq),
  .pend        (pend),
  .gstat       (gstat),
  .istat0      (chk_istat0),
  .ien0        (chk_ien0)
);

// File: tb/sata_hba_regs_bench.sv
module sata_hba_regs_bench;

  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          dev_present = 1'b0;
  logic [NP*32-1:0] evt_set = '0;
  logic [NP*32-1:0] slot_done = '0;
  logic [NP-1:0] kick;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sata_hba_regs #(.NPORT(NP)) u_sata_hba_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_present(dev_present),
    .evt_set(evt_set), .slot_done(slot_done), .kick(kick), .irq(irq)
  );

  // bench model of plain storage, index = port*16 + word
  logic [31:0] mdl [32];

  function automatic logic [11:0] paddr(input int p, input int off);
    return 12'(256 + p * 128 + off);
  endfunction

  function automatic logic [31:0] cmd_expect(input logic [31:0] v);
    logic [31:0] r;
    r = '0;
    r[24] = v[24]; r[15] = v[15]; r[14] = v[14];
    r[4:0] = v[4:0];
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] e,
                           input string req);
    logic [31:0] v;
    rd(a, v);
    check(v == e, req, v, e);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int plain_off [9] = '{'h00, 'h04, 'h08, 'h0C, 'h14, 'h20, 'h24, 'h2C, 'h30};
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) mdl[i] = '0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_rd(12'h000, 32'h0000_1F02, "R1 cap");
    expect_rd(12'h004, 32'h8000_0000, "R1 ctl");
    expect_rd(12'h00C, 32'h0000_0001, "R1 impl");
    expect_rd(12'h010, 32'h0001_0100, "R1 ver");
    expect_rd(12'h008, 32'h0, "R1 summary");
    expect_rd(paddr(1, 'h38), 32'h0, "R1 issue");
    check(irq == 1'b0, "R1 irq", {31'b0, irq}, 0);

    // R2 holes
    expect_rd(12'h014, 32'h0, "R2 global hole");
    expect_rd(paddr(0, 'h1C), 32'h0, "R2 port hole 1C");
    expect_rd(paddr(1, 'h40), 32'h0, "R2 port hole 40");
    expect_rd(12'h200, 32'h0, "R2 outside");

    // R3 global read-only
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h004, 32'h0);
    wr(12'h00C, 32'hFF);
    wr(12'h010, 32'h0);
    expect_rd(12'h000, 32'h0000_1F02, "R3 cap");
    expect_rd(12'h004, 32'h8000_0000, "R3 ctl");
    expect_rd(12'h00C, 32'h0000_0001, "R3 impl");
    expect_rd(12'h010, 32'h0001_0100, "R3 ver");

    // R11 / R4 / R9 random traffic
    for (int n = 0; n < 300; n++) begin
      int p = $urandom_range(0, 1);
      logic [31:0] d = $urandom();
      if ($urandom_range(0, 3) == 0) begin
        wr(paddr(p, 'h18), d);
        check(kick[p] == d[0], "R9 kick on command write", {31'b0, kick[p]}, {31'b0, d[0]});
        check(kick[1-p] == 1'b0, "R9 other port quiet", {31'b0, kick[1-p]}, 0);
        expect_rd(paddr(p, 'h18), cmd_expect(d), "R4 command mask");
      end else begin
        int o = plain_off[$urandom_range(0, 8)];
        wr(paddr(p, o), d);
        mdl[p * 16 + o / 4] = d;
        begin
          int q = $urandom_range(0, 1);
          int o2 = plain_off[$urandom_range(0, 8)];
          expect_rd(paddr(q, o2), mdl[q * 16 + o2 / 4], "R11 storage readback");
        end
      end
    end

    // R7 link status
    dev_present = 1'b1;
    expect_rd(paddr(0, 'h28), 32'h3, "R7 port0 present");
    expect_rd(paddr(1, 'h28), 32'h0, "R7 port1");
    wr(paddr(0, 'h28), 32'hFF);
    expect_rd(paddr(0, 'h28), 32'h3, "R7 write ignored");
    dev_present = 1'b0;
    expect_rd(paddr(0, 'h28), 32'h0, "R7 absent");

    // R8 misaligned
    wr(paddr(0, 'h00), 32'h1111_0000);
    wr(paddr(0, 'h01), 32'hDEAD_BEEF);
    expect_rd(paddr(0, 'h00), 32'h1111_0000, "R8 base untouched");
    wr(paddr(0, 'h19), 32'h0000_0001);
    check(kick == '0, "R8 no kick", {30'b0, kick}, 0);
    wr(paddr(0, 'h3A), 32'h5);
    check(kick == '0, "R8 no kick on issue", {30'b0, kick}, 0);

    // clear interrupt enables for directed interrupt tests
    wr(paddr(0, 'h14), 32'h0);
    wr(paddr(1, 'h14), 32'h0);

    // R5 / R6 interrupts
    @(negedge clk); evt_set[31:0] = 32'h5;
    @(negedge clk); evt_set = '0;
    expect_rd(paddr(0, 'h10), 32'h5, "R5 event captured");
    @(negedge clk);
    check(irq == 1'b0, "R6 masked no irq", {31'b0, irq}, 0);
    wr(paddr(0, 'h14), 32'h1);
    @(negedge clk);
    check(irq == 1'b1, "R6 irq on enabled cause", {31'b0, irq}, 1);
    expect_rd(12'h008, 32'h1, "R6 summary bit0");
    wr(12'h008, 32'h1);
    @(negedge clk);
    expect_rd(12'h008, 32'h1, "R6 pending re-sets summary");
    wr(paddr(0, 'h10), 32'h1);
    expect_rd(paddr(0, 'h10), 32'h4, "R5 w1c");
    @(negedge clk);
    expect_rd(12'h008, 32'h1, "R6 sticky after cause gone");
    check(irq == 1'b1, "R6 irq held", {31'b0, irq}, 1);
    wr(12'h008, 32'h1);
    @(negedge clk);
    expect_rd(12'h008, 32'h0, "R6 summary cleared");
    check(irq == 1'b0, "R6 irq low", {31'b0, irq}, 0);

    // R5 set wins over same-cycle clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = paddr(0, 'h10); bus_wdata = 32'h4;
    evt_set[31:0] = 32'h4;
    @(negedge clk);
    bus_wr = 1'b0; evt_set = '0;
    expect_rd(paddr(0, 'h10), 32'h4, "R5 set wins");

    // R6 port 1
    wr(paddr(1, 'h14), 32'h8);
    @(negedge clk); evt_set[35] = 1'b1;
    @(negedge clk); evt_set = '0;
    @(negedge clk);
    expect_rd(12'h008, 32'h2, "R6 port1 summary");
    check(irq == 1'b1, "R6 irq port1", {31'b0, irq}, 1);

    // R9 / R10 command issue
    wr(paddr(0, 'h38), 32'hF0);
    check(kick == 2'b01, "R9 issue kick", {30'b0, kick}, 1);
    @(negedge clk);
    check(kick == 2'b00, "R9 single cycle", {30'b0, kick}, 0);
    expect_rd(paddr(0, 'h38), 32'hF0, "R10 issue write");
    @(negedge clk); slot_done[31:0] = 32'h10;
    @(negedge clk); slot_done = '0;
    expect_rd(paddr(0, 'h38), 32'hE0, "R10 done clears");
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = paddr(0, 'h38); bus_wdata = 32'h3;
    slot_done[31:0] = 32'h3;
    @(negedge clk);
    bus_wr = 1'b0; slot_done = '0;
    expect_rd(paddr(0, 'h38), 32'h3, "R10 write wins");
    wr(paddr(1, 'h18), 32'h2);
    check(kick == 2'b00, "R9 no kick without start", {30'b0, kick}, 0);
    wr(paddr(1, 'h18), 32'hFFFF_FFFF);
    check(kick == 2'b10, "R9 port1 start kick", {30'b0, kick}, 2);
    expect_rd(paddr(1, 'h18), 32'h0100_C01F, "R4 all ones");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule